// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

A four-bit counter with no direction bit. It has one strobe input for counting up and another for counting down. Both strobes are idle high. A count step happens on the rising edge of one strobe while the other strobe is held high. The `DECADE` parameter selects the count sequence: 0 to 9 when set, 0 to 15 when clear. All state lives in the single system clock domain. Each strobe passes through a two-flop synchronizer, and the counter acts on rising edges seen after that synchronizer.

Two inputs override counting. A high level on `clr` clears the count asynchronously, and it wins over every other input. A low level on `load_n` copies the preset bus into the count on every clock edge for as long as it stays low.

There are two active-low terminal-count outputs, one for each direction. Each is qualified by the level of its own strobe. It falls half a strobe period before the wrap and rises again when the wrap completes. A wider counter is built by chaining stages: the carry output of a lower stage drives the up strobe of the next stage, and the borrow output drives the next stage's down strobe.

Top module: `updown_strobe_counter`

## Requirements
- R1: While `clr` is high, `count` is 0. The clear is asynchronous and overrides `load_n` and both strobes. After `clr` falls, `count` stays 0 until a load or a count step changes it.
- R2: While `load_n` is low and `clr` is low, each rising clock edge writes `preset` into `count`. Strobe edges during this time have no effect.
- R3: A rising edge on `up_stb` while `dn_stb` is high adds one to `count`. The strobe is synchronized, so the new value appears after the third rising clock edge following the strobe change.
- R4: A rising edge on `dn_stb` while `up_stb` is high subtracts one from `count`, with the same latency as R3.
- R5: The top value is 9 when `DECADE` is 1 and 15 when `DECADE` is 0. Counting up from the top value gives 0. Counting down from 0 gives the top value.
- R6: `carry_n` is low exactly when `count` equals the top value and the synchronized `up_stb` is low. Otherwise it is high.
- R7: `borrow_n` is low exactly when `count` is 0 and the synchronized `dn_stb` is low. Otherwise it is high.
- R8: With `DECADE` set to 1, an up step from any value in 10 to 15 gives 0, and a down step from any value in 10 to 15 gives 9. A loaded value in that range is kept until the next step.
- R9: A rising edge on one strobe while the other strobe is low leaves `count` unchanged. A falling edge on either strobe also leaves `count` unchanged.
- R10: Two decade stages can be chained, with the lower stage's `carry_n` driving the upper stage's `up_stb` and its `borrow_n` driving the upper stage's `dn_stb`. The chain then counts 0 to 99 in both directions and wraps at both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| load_n | input | 1 | Parallel load enable, active low |
| preset | input | W | Value loaded while `load_n` is low |
| up_stb | input | 1 | Count-up strobe, idle high, counts on its rising edge |
| dn_stb | input | 1 | Count-down strobe, idle high, counts on its rising edge |
| count | output | W | Current count |
| carry_n | output | 1 | Up terminal count, active low |
| borrow_n | output | 1 | Down terminal count, active low |

## Verification
The bench drives one decade instance and one binary instance with the same stimulus, so the two wrap points are checked against each other. A design that hard-codes the top value therefore wraps one of the two instances at the wrong count.

The bench loads every illegal decade value and steps it once in each direction. A design that increments without a range check would walk through 10 to 15 instead of recovering.

Carry and borrow are checked while the strobe is low, both at the top value and away from it. A terminal count that is not gated by the strobe would give the chained upper stage no rising edge and stall the two-stage chain. The bench also checks that a strobe edge is ignored while the other strobe is low and while a load is active, and it checks the exact three-edge latency of a count step.

// File: rtl/updown_strobe_counter.sv
`timescale 1ns/1ps
module updown_strobe_counter #(
  parameter bit DECADE = 1'b1,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         up_stb,
  input  logic         dn_stb,
  output logic [W-1:0] count,
  output logic         carry_n,
  output logic         borrow_n
);
  localparam logic [W-1:0] TOP  = DECADE ? W'(9) : {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  logic [2:0] up_sh, dn_sh;
  logic       up_lvl, dn_lvl, up_rise, dn_rise;
  logic       step_up, step_dn;
  logic [W-1:0] cnt_inc, cnt_dec;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      up_sh <= '1;
      dn_sh <= '1;
    end else begin
      up_sh <= {up_sh[1:0], up_stb};
      dn_sh <= {dn_sh[1:0], dn_stb};
    end
  end

  assign up_lvl  = up_sh[1];
  assign dn_lvl  = dn_sh[1];
  assign up_rise = up_sh[1] & ~up_sh[2];
  assign dn_rise = dn_sh[1] & ~dn_sh[2];
  assign step_up = up_rise & dn_lvl;
  assign step_dn = dn_rise & up_lvl;

  assign cnt_inc = (count >= TOP) ? ZERO : count + W'(1);
  assign cnt_dec = (count == ZERO || count > TOP) ? TOP : count - W'(1);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)          count <= ZERO;
    else if (!load_n) count <= preset;
    else if (step_up) count <= cnt_inc;
    else if (step_dn) count <= cnt_dec;
  end

  assign carry_n  = ~((count == TOP)  & ~up_lvl);
  assign borrow_n = ~((count == ZERO) & ~dn_lvl);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> count == ZERO);  // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (clr)
    !load_n |=> count == $past(preset));  // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (clr)
    (load_n && up_rise && dn_lvl) |=> (count == ZERO || count == $past(count) + W'(1)));  // R3
  AST_DN_STEP: assert property (@(posedge clk) disable iff (clr)
    (load_n && dn_rise && up_lvl) |=> (count == TOP || count == $past(count) - W'(1)));  // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    (load_n && !(up_rise && dn_lvl) && !(dn_rise && up_lvl)) |=> $stable(count));  // R9
  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (clr)
    !carry_n |-> count == TOP);  // R6
  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (clr)
    !borrow_n |-> count == ZERO);  // R7
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (clr)
    (load_n && ((up_rise && dn_lvl) || (dn_rise && up_lvl))) |=> count <= TOP);  // R8
endmodule

// File: tb/test_updown_strobe_counter.sv
`timescale 1ns/1ps
module test_updown_strobe_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr = 1'b1, load_n = 1'b1, up = 1'b1, dn = 1'b1;
  logic [3:0] preset = '0;
  logic [3:0] q_dec, q_bin;
  logic       cy_dec, bw_dec, cy_bin, bw_bin;

  logic       cclr = 1'b1, cup = 1'b1, cdn = 1'b1;
  logic [3:0] q_lo, q_hi;
  logic       cy_lo, bw_lo, cy_hi, bw_hi;

  int checks = 0, fails = 0;
  int ed, eb;

  updown_strobe_counter #(.DECADE(1'b1)) i_updown_strobe_counter (
    .clk(clk), .clr(clr), .load_n(load_n), .preset(preset), .up_stb(up), .dn_stb(dn),
    .count(q_dec), .carry_n(cy_dec), .borrow_n(bw_dec));
  updown_strobe_counter #(.DECADE(1'b0)) i_bin (
    .clk(clk), .clr(clr), .load_n(load_n), .preset(preset), .up_stb(up), .dn_stb(dn),
    .count(q_bin), .carry_n(cy_bin), .borrow_n(bw_bin));
  updown_strobe_counter #(.DECADE(1'b1)) i_lo (
    .clk(clk), .clr(cclr), .load_n(1'b1), .preset(4'd0), .up_stb(cup), .dn_stb(cdn),
    .count(q_lo), .carry_n(cy_lo), .borrow_n(bw_lo));
  updown_strobe_counter #(.DECADE(1'b1)) i_hi (
    .clk(clk), .clr(cclr), .load_n(1'b1), .preset(4'd0), .up_stb(cy_lo), .dn_stb(bw_lo),
    .count(q_hi), .carry_n(cy_hi), .borrow_n(bw_hi));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; waitn(8); up = 1'b1; waitn(8);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; waitn(8); dn = 1'b1; waitn(8);
  endtask

  task automatic load(input int v);
    preset = 4'(v); load_n = 1'b0; waitn(2); load_n = 1'b1; waitn(1);
  endtask

  initial begin
    waitn(4000000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitn(3);
    check("R1 reset count", int'(q_dec), 0);
    check("R1 reset carry", int'(cy_dec), 1);
    check("R1 reset borrow", int'(bw_dec), 1);
    clr = 1'b0; cclr = 1'b0; waitn(4);

    // R3 latency: new value after the third rising edge
    up = 1'b0; waitn(8); up = 1'b1; waitn(2);
    check("R3 latency before", int'(q_dec), 0);
    waitn(1);
    check("R3 latency after", int'(q_dec), 1);
    waitn(6);
    ed = 1; eb = 1;

    // R3 R5 up sweep in both modes
    for (int i = 0; i < 24; i++) begin
      pulse_up();
      ed = (ed + 1) % 10; eb = (eb + 1) % 16;
      check("R3 R5 up decade", int'(q_dec), ed);
      check("R3 R5 up binary", int'(q_bin), eb);
    end
    // R4 R5 down sweep
    for (int i = 0; i < 25; i++) begin
      pulse_dn();
      ed = (ed + 9) % 10; eb = (eb + 15) % 16;
      check("R4 R5 down decade", int'(q_dec), ed);
      check("R4 R5 down binary", int'(q_bin), eb);
    end

    // R2 every preset value, held through a strobe edge
    for (int v = 0; v < 16; v++) begin
      load(v);
      check("R2 load decade", int'(q_dec), v);
      check("R2 load binary", int'(q_bin), v);
    end
    preset = 4'd6; load_n = 1'b0; pulse_up(); pulse_dn();
    check("R2 strobes ignored under load", int'(q_bin), 6);
    load_n = 1'b1; waitn(1);

    // R6 carry
    load(9); up = 1'b0; waitn(8);
    check("R6 carry low at 9 decade", int'(cy_dec), 0);
    check("R6 carry high at 9 binary", int'(cy_bin), 1);
    up = 1'b1; waitn(8);
    check("R6 carry released decade", int'(cy_dec), 1);
    check("R5 decade wrap to 0", int'(q_dec), 0);
    check("R5 binary 9 to 10", int'(q_bin), 10);
    load(15); up = 1'b0; waitn(8);
    check("R6 carry low at 15 binary", int'(cy_bin), 0);
    check("R6 carry high at 15 decade", int'(cy_dec), 1);
    up = 1'b1; waitn(8);
    check("R6 carry released binary", int'(cy_bin), 1);
    check("R5 binary wrap to 0", int'(q_bin), 0);

    // R7 borrow
    load(0); dn = 1'b0; waitn(8);
    check("R7 borrow low decade", int'(bw_dec), 0);
    check("R7 borrow low binary", int'(bw_bin), 0);
    dn = 1'b1; waitn(8);
    check("R7 borrow released", int'(bw_dec), 1);
    check("R5 decade down wrap", int'(q_dec), 9);
    check("R5 binary down wrap", int'(q_bin), 15);
    load(4); dn = 1'b0; waitn(8);
    check("R7 borrow high off zero", int'(bw_dec), 1);
    dn = 1'b1; waitn(8);

    // R8 illegal decade recovery
    for (int v = 10; v < 16; v++) begin
      load(v);
      check("R8 illegal held", int'(q_dec), v);
      pulse_up();
      check("R8 illegal up", int'(q_dec), 0);
      check("R8 binary up", int'(q_bin), (v + 1) % 16);
      load(v); pulse_dn();
      check("R8 illegal down", int'(q_dec), 9);
      check("R8 binary down", int'(q_bin), v - 1);
    end

    // R9 edge with the other strobe low
    load(5);
    dn = 1'b0; waitn(8);
    pulse_up();
    check("R9 up edge while down low", int'(q_dec), 5);
    dn = 1'b1; waitn(8);
    check("R9 then down edge counts", int'(q_dec), 4);

    // R1 clear beats load and strobes
    preset = 4'd7; load_n = 1'b0; clr = 1'b1; waitn(3);
    check("R1 clear over load", int'(q_dec), 0);
    pulse_up();
    check("R1 clear over strobe", int'(q_bin), 0);
    load_n = 1'b1; clr = 1'b0; waitn(4);
    check("R1 zero after release", int'(q_dec), 0);

    // R10 two-stage chain
    for (int n = 1; n <= 104; n++) begin
      cup = 1'b0; waitn(8); cup = 1'b1; waitn(10);
      check("R10 chain up", int'(q_hi) * 10 + int'(q_lo), n % 100);
    end
    for (int n = 1; n <= 7; n++) begin
      cdn = 1'b0; waitn(8); cdn = 1'b1; waitn(10);
      check("R10 chain down", int'(q_hi) * 10 + int'(q_lo), (104 - n + 100) % 100);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule